// File: doc/BRIEF.md
# Dead-Time Waveform Generator

This block drives a complementary output pair from a 16-bit down-counting dead timer. A control word selects its role. It can be stopped. It can pass a pulse train only while a trigger line is high. It can open a pulse window that each rising trigger edge starts and that the timer's underflow closes. It can also generate a non-overlapping complementary pair whose source is either the trigger line or the pulse train. In the non-overlap roles, every source edge reloads the timer from a software-written reload value. The output that is about to switch on stays low until the timer underflows, so the two outputs are never high together.

A polarity bit inverts both outputs. A separate gate output combines two auxiliary trigger lines. Each line is either enabled to control the gate or ignored. Every underflow sets a sticky flag. Software clears the flag by writing zero to it. An interrupt request follows the flag when the enable bit is set.

Top module: `dtw_gen`

## Requirements
- R1: After reset the mode is stop, polarity is normal, the flag and interrupt enable are 0, both outputs are 0, and the gate output is 1 because no auxiliary line is enabled.
- R2: Mode code 000, and any code other than 001, 010, 100 and 111, stops the generator. Both outputs sit at the polarity level, and trigger edges never load the timer or set the flag.
- R3: In mode 001, out_p in each cycle equals ppg_in AND rt_in sampled at the previous clock edge, and out_n is its complement.
- R4: In mode 010, a rising edge of rt_in loads the timer. out_p then follows ppg_in, delayed by one register, for reload+1 cycles starting one cycle after the loading edge. Outside that window it is 0, and out_n is its complement.
- R5: A loaded timer counts down once per cycle. The step from 0 is an underflow. It sets the flag exactly reload+1 edges after the loading edge, then the timer holds 0 until it is loaded again. A reload while the timer is running restarts the count.
- R6: In mode 100, every edge of rt_in loads the timer. The output that is switching off falls two edges after the input changes, and the output that is switching on rises reload+3 edges after the input changes.
- R7: Mode 111 behaves as R6, with ppg_in as the source.
- R8: With normal polarity, out_p and out_n are never both 1.
- R9: A control write with ctl_flag_wr=0 clears the flag, and a write with ctl_flag_wr=1 leaves it unchanged. An underflow in the same cycle as a clear takes priority.
- R10: irq_req is 1 exactly when the flag and the interrupt enable are both 1.
- R11: gate_o is 1 when every auxiliary line whose ctl_gate_sync bit is 1 is high. Lines whose sync bit is 0 have no effect on it. This output is combinational.
- R12: Polarity 1 inverts both outputs, one cycle after the control write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_mode | input | 3 | Mode code |
| ctl_pol | input | 1 | Output polarity, 1 inverts |
| ctl_irq_en | input | 1 | Interrupt enable |
| ctl_flag_wr | input | 1 | Flag write value, 0 clears, 1 leaves the flag unchanged |
| ctl_gate_sync | input | GATE_N | Per-line gate control enable |
| reload_we | input | 1 | Reload value write strobe |
| reload_val | input | CNT_W | Reload value |
| rt_in | input | 1 | Main trigger line |
| ppg_in | input | 1 | Pulse train input |
| gate_rt_in | input | GATE_N | Auxiliary trigger lines for the gate |
| out_p | output | 1 | Primary waveform output |
| out_n | output | 1 | Complementary waveform output |
| gate_o | output | 1 | Gate output |
| irq_flag | output | 1 | Sticky underflow flag |
| irq_req | output | 1 | Interrupt request |

## Verification
A counter that loads or decrements wrongly moves the underflow edge. The flag then rises one or more cycles away from reload+1 edges after the trigger, and in the pulse-window and non-overlap modes the output that switches on moves by the same amount. A wrong edge register or source selection shows within two cycles of a trigger change: either an output falls late or never, or a stopped mode sets the flag. A faulty polarity or flag-clear path shows at the outputs one cycle after the control write.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

    typedef enum logic [2:0] {
        MODE_STOP   = 3'b000,
        MODE_GATE   = 3'b001,
        MODE_TIMER  = 3'b010,
        MODE_DT_RT  = 3'b100,
        MODE_DT_PPG = 3'b111
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  pol;
        logic  irq_en;
    } ctl_t;

    typedef struct packed {
        logic p;
        logic n;
    } pair_t;

    localparam ctl_t CTL_RESET = '{mode: MODE_STOP, pol: 1'b0, irq_en: 1'b0};

    // Unlisted codes fall back to stop.
    function automatic mode_e decode_mode(input logic [2:0] code);
        mode_e m;
        case (code)
            3'b001:  m = MODE_GATE;
            3'b010:  m = MODE_TIMER;
            3'b100:  m = MODE_DT_RT;
            3'b111:  m = MODE_DT_PPG;
            default: m = MODE_STOP;
        endcase
        return m;
    endfunction

    function automatic logic mode_is_dt(input mode_e m);
        return (m == MODE_DT_RT) || (m == MODE_DT_PPG);
    endfunction

    function automatic logic mode_counts(input mode_e m);
        return (m == MODE_TIMER) || mode_is_dt(m);
    endfunction

endpackage

// File: rtl/dtw_ctl.sv
module dtw_ctl
    import dtw_pkg::*;
#(
    parameter int unsigned GATE_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        wr_mode,
    input  logic              wr_pol,
    input  logic              wr_irq_en,
    input  logic              wr_flag,
    input  logic [GATE_N-1:0] wr_gsync,
    input  logic              uf,
    output ctl_t              ctl_q,
    output logic [GATE_N-1:0] gsync_q,
    output logic              flag_q,
    output logic              irq_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= CTL_RESET;
            gsync_q <= '0;
        end else if (we) begin
            ctl_q.mode   <= decode_mode(wr_mode);
            ctl_q.pol    <= wr_pol;
            ctl_q.irq_en <= wr_irq_en;
            gsync_q      <= wr_gsync;
        end
    end

    // Underflow wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (uf) begin
            flag_q <= 1'b1;
        end else if (we && !wr_flag) begin
            flag_q <= 1'b0;
        end
    end

    assign irq_req = flag_q & ctl_q.irq_en;

endmodule

// File: rtl/dtw_counter.sv
module dtw_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             uf
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    assign uf = run && (cnt == ZERO);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt <= ZERO;
            run <= 1'b0;
        end else if (load) begin
            cnt <= reload;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == ZERO) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end

endmodule

// File: rtl/dtw_wave.sv
module dtw_wave
    import dtw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  pol,
    input  logic  rt,
    input  logic  ppg,
    input  logic  run,
    output logic  load,
    output logic  out_p,
    output logic  out_n
);

    logic  rt_d;
    logic  ppg_d;
    pair_t raw;
    pair_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rt_d  <= 1'b0;
            ppg_d <= 1'b0;
        end else begin
            rt_d  <= rt;
            ppg_d <= ppg;
        end
    end

    always_comb begin
        raw  = '{p: 1'b0, n: 1'b0};
        load = 1'b0;
        case (mode)
            MODE_GATE: begin
                raw.p = ppg & rt;
                raw.n = ~(ppg & rt);
            end
            MODE_TIMER: begin
                load  = rt & ~rt_d;
                raw.p = ppg & run;
                raw.n = ~(ppg & run);
            end
            MODE_DT_RT: begin
                load  = rt ^ rt_d;
                raw.p = rt_d & ~run;
                raw.n = ~rt_d & ~run;
            end
            MODE_DT_PPG: begin
                load  = ppg ^ ppg_d;
                raw.p = ppg_d & ~run;
                raw.n = ~ppg_d & ~run;
            end
            default: begin
                raw  = '{p: 1'b0, n: 1'b0};
                load = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '{p: 1'b0, n: 1'b0};
        end else begin
            out_q.p <= raw.p ^ pol;
            out_q.n <= raw.n ^ pol;
        end
    end

    assign out_p = out_q.p;
    assign out_n = out_q.n;

endmodule

// File: rtl/dtw_gate.sv
module dtw_gate #(
    parameter int unsigned GATE_N = 2
) (
    input  logic [GATE_N-1:0] sync,
    input  logic [GATE_N-1:0] lines,
    output logic              gate
);

    logic [GATE_N-1:0] term;

    for (genvar i = 0; i < GATE_N; i++) begin : g_term
        assign term[i] = ~sync[i] | lines[i];
    end

    assign gate = &term;

endmodule

// File: rtl/dtw_gen.sv
module dtw_gen
    import dtw_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned GATE_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [2:0]        ctl_mode,
    input  logic              ctl_pol,
    input  logic              ctl_irq_en,
    input  logic              ctl_flag_wr,
    input  logic [GATE_N-1:0] ctl_gate_sync,
    input  logic              reload_we,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic              rt_in,
    input  logic              ppg_in,
    input  logic [GATE_N-1:0] gate_rt_in,
    output logic              out_p,
    output logic              out_n,
    output logic              gate_o,
    output logic              irq_flag,
    output logic              irq_req
);

    ctl_t              ctl_q;
    logic [GATE_N-1:0] gsync_q;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  cnt;
    logic              run;
    logic              uf;
    logic              load;
    logic              cnt_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else if (reload_we) begin
            reload_q <= reload_val;
        end
    end

    assign cnt_en = mode_counts(ctl_q.mode);

    dtw_ctl #(.GATE_N(GATE_N)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .we        (ctl_we),
        .wr_mode   (ctl_mode),
        .wr_pol    (ctl_pol),
        .wr_irq_en (ctl_irq_en),
        .wr_flag   (ctl_flag_wr),
        .wr_gsync  (ctl_gate_sync),
        .uf        (uf),
        .ctl_q     (ctl_q),
        .gsync_q   (gsync_q),
        .flag_q    (irq_flag),
        .irq_req   (irq_req)
    );

    dtw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .enable (cnt_en),
        .load   (load),
        .reload (reload_q),
        .cnt    (cnt),
        .run    (run),
        .uf     (uf)
    );

    dtw_wave u_wave (
        .clk   (clk),
        .rst   (rst),
        .mode  (ctl_q.mode),
        .pol   (ctl_q.pol),
        .rt    (rt_in),
        .ppg   (ppg_in),
        .run   (run),
        .load  (load),
        .out_p (out_p),
        .out_n (out_n)
    );

    dtw_gate #(.GATE_N(GATE_N)) u_gate (
        .sync  (gsync_q),
        .lines (gate_rt_in),
        .gate  (gate_o)
    );

endmodule

// File: rtl/dtw_gen_chk.sv
module dtw_gen_chk
    import dtw_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input mode_e            mode,
    input logic             pol,
    input logic             irq_en,
    input logic             we,
    input logic             wr_flag,
    input logic             run,
    input logic             load,
    input logic             uf,
    input logic [CNT_W-1:0] cnt,
    input logic             out_p,
    input logic             out_n,
    input logic             flag,
    input logic             irq_req
);

    localparam logic [CNT_W-1:0] ZERO = '0;

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        (!pol && !$past(pol)) |-> !(out_p && out_n));

    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STOP) |=> !run);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt != ZERO && mode_counts(mode)) |=> (cnt == $past(cnt) - 1'b1));

    assert_uf_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        uf |=> flag);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (we && !wr_flag && !uf) |=> !flag);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (flag && !(we && !wr_flag)) |=> flag);

    assert_dead_band_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_is_dt(mode) && run) |=> (out_p == $past(pol) && out_n == $past(pol)));

    assert_irq_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (uf && irq_en && !we) |=> irq_req);

endmodule

bind dtw_gen dtw_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (ctl_q.mode),
    .pol     (ctl_q.pol),
    .irq_en  (ctl_q.irq_en),
    .we      (ctl_we),
    .wr_flag (ctl_flag_wr),
    .run     (run),
    .load    (load),
    .uf      (uf),
    .cnt     (cnt),
    .out_p   (out_p),
    .out_n   (out_n),
    .flag    (irq_flag),
    .irq_req (irq_req)
);

// File: tb/dtw_gen_bench.sv
`timescale 1ns/1ps
module dtw_gen_bench;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned GATE_N = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctl_we = 1'b0;
    logic [2:0]        ctl_mode = 3'b000;
    logic              ctl_pol = 1'b0;
    logic              ctl_irq_en = 1'b0;
    logic              ctl_flag_wr = 1'b1;
    logic [GATE_N-1:0] ctl_gate_sync = '0;
    logic              reload_we = 1'b0;
    logic [CNT_W-1:0]  reload_val = '0;
    logic              rt_in = 1'b0;
    logic              ppg_in = 1'b0;
    logic [GATE_N-1:0] gate_rt_in = '0;
    logic              out_p;
    logic              out_n;
    logic              gate_o;
    logic              irq_flag;
    logic              irq_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dtw_gen #(.CNT_W(CNT_W), .GATE_N(GATE_N)) u_dtw_gen (
        .clk           (clk),
        .rst           (rst),
        .ctl_we        (ctl_we),
        .ctl_mode      (ctl_mode),
        .ctl_pol       (ctl_pol),
        .ctl_irq_en    (ctl_irq_en),
        .ctl_flag_wr   (ctl_flag_wr),
        .ctl_gate_sync (ctl_gate_sync),
        .reload_we     (reload_we),
        .reload_val    (reload_val),
        .rt_in         (rt_in),
        .ppg_in        (ppg_in),
        .gate_rt_in    (gate_rt_in),
        .out_p         (out_p),
        .out_n         (out_n),
        .gate_o        (gate_o),
        .irq_flag      (irq_flag),
        .irq_req       (irq_req)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [2:0] m, input logic pol, input logic ie,
                          input logic fw, input logic [GATE_N-1:0] gs);
        ctl_we = 1'b1; ctl_mode = m; ctl_pol = pol; ctl_irq_en = ie;
        ctl_flag_wr = fw; ctl_gate_sync = gs;
        step();
        ctl_we = 1'b0; ctl_flag_wr = 1'b1;
    endtask

    task automatic set_reload(input int v);
        reload_we = 1'b1; reload_val = CNT_W'(v);
        step();
        reload_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "out_p", out_p, 0);
        chk("R1", "out_n", out_n, 0);
        chk("R1", "flag", irq_flag, 0);
        chk("R1", "irq", irq_req, 0);
        chk("R1", "gate", gate_o, 1);
    endtask

    task automatic t_stop();
        set_reload(0);
        wr_ctl(3'b011, 1'b0, 1'b0, 1'b1, '0);
        ppg_in = 1'b1;
        for (int i = 0; i < 6; i++) begin
            rt_in = ~rt_in;
            step();
        end
        chk("R2", "flag unlisted code", irq_flag, 0);
        chk("R2", "out_p unlisted code", out_p, 0);
        wr_ctl(3'b000, 1'b0, 1'b0, 1'b1, '0);
        for (int i = 0; i < 4; i++) begin
            rt_in = ~rt_in;
            step();
        end
        chk("R2", "flag stop", irq_flag, 0);
        chk("R2", "out_n stop", out_n, 0);
        rt_in = 1'b0; ppg_in = 1'b0;
        step();
    endtask

    task automatic t_gate();
        wr_ctl(3'b001, 1'b0, 1'b0, 1'b1, '0);
        rt_in = 1'b1; ppg_in = 1'b1;
        step();
        chk("R3", "out_p rt&ppg", out_p, 1);
        chk("R3", "out_n rt&ppg", out_n, 0);
        ppg_in = 1'b0;
        step();
        chk("R3", "out_p ppg low", out_p, 0);
        chk("R3", "out_n ppg low", out_n, 1);
        rt_in = 1'b0; ppg_in = 1'b1;
        step();
        chk("R3", "out_p rt low", out_p, 0);
        ppg_in = 1'b0;
    endtask

    task automatic t_timer();
        set_reload(3);
        wr_ctl(3'b010, 1'b0, 1'b0, 1'b0, '0);
        rt_in = 1'b0; ppg_in = 1'b1;
        step(); step();
        chk("R4", "out_p idle", out_p, 0);
        chk("R4", "out_n idle", out_n, 1);
        rt_in = 1'b1;
        for (int s = 1; s <= 6; s++) begin
            step();
            chk("R4", $sformatf("out_p window s=%0d", s), out_p, (s >= 2 && s <= 5) ? 1 : 0);
            chk("R5", $sformatf("flag s=%0d", s), irq_flag, (s >= 5) ? 1 : 0);
        end
        chk("R4", "out_n after window", out_n, 1);
        wr_ctl(3'b010, 1'b0, 1'b0, 1'b1, '0);
        chk("R9", "flag kept by write 1", irq_flag, 1);
        wr_ctl(3'b010, 1'b0, 1'b0, 1'b0, '0);
        chk("R9", "flag cleared by write 0", irq_flag, 0);
        step();
        chk("R5", "no re-underflow while held", irq_flag, 0);
        rt_in = 1'b0;
        step();
    endtask

    task automatic t_retrig();
        set_reload(5);
        wr_ctl(3'b010, 1'b0, 1'b0, 1'b0, '0);
        rt_in = 1'b0; ppg_in = 1'b1;
        step(); step();
        rt_in = 1'b1;
        step(); step();
        rt_in = 1'b0;
        step();
        rt_in = 1'b1;
        for (int s = 1; s <= 7; s++) begin
            step();
            if (s >= 4) chk("R5", $sformatf("retrigger flag s=%0d", s), irq_flag, (s == 7) ? 1 : 0);
        end
        rt_in = 1'b0; ppg_in = 1'b0;
        step();
    endtask

    task automatic t_dt(input logic [2:0] m, input int n, input string req, input bit use_ppg);
        set_reload(n);
        rt_in = 1'b0; ppg_in = 1'b0;
        wr_ctl(m, 1'b0, 1'b0, 1'b0, '0);
        step(); step(); step();
        chk(req, "out_n idle", out_n, 1);
        chk(req, "out_p idle", out_p, 0);
        if (use_ppg) ppg_in = 1'b1; else rt_in = 1'b1;
        for (int s = 1; s <= n + 4; s++) begin
            step();
            chk(req, $sformatf("rise out_n s=%0d", s), out_n, (s >= 2) ? 0 : 1);
            chk(req, $sformatf("rise out_p s=%0d", s), out_p, (s >= n + 3) ? 1 : 0);
            chk("R8", "no overlap", int'(out_p & out_n), 0);
        end
        if (use_ppg) ppg_in = 1'b0; else rt_in = 1'b0;
        for (int s = 1; s <= n + 4; s++) begin
            step();
            chk(req, $sformatf("fall out_p s=%0d", s), out_p, (s >= 2) ? 0 : 1);
            chk(req, $sformatf("fall out_n s=%0d", s), out_n, (s >= n + 3) ? 1 : 0);
            chk("R8", "no overlap", int'(out_p & out_n), 0);
        end
    endtask

    task automatic t_irq();
        chk("R10", "flag set before irq test", irq_flag, 1);
        chk("R10", "irq masked", irq_req, 0);
        wr_ctl(3'b000, 1'b0, 1'b1, 1'b1, '0);
        chk("R10", "irq enabled", irq_req, 1);
        wr_ctl(3'b000, 1'b0, 1'b1, 1'b0, '0);
        chk("R10", "irq after clear", irq_req, 0);
    endtask

    task automatic t_pol();
        wr_ctl(3'b000, 1'b1, 1'b0, 1'b1, '0);
        step();
        chk("R12", "out_p inverted", out_p, 1);
        chk("R12", "out_n inverted", out_n, 1);
        wr_ctl(3'b000, 1'b0, 1'b0, 1'b1, '0);
        step();
        chk("R12", "out_p normal", out_p, 0);
    endtask

    task automatic t_gatesync();
        wr_ctl(3'b000, 1'b0, 1'b0, 1'b1, 2'b01);
        gate_rt_in = 2'b00; #1;
        chk("R11", "line0 low synced", gate_o, 0);
        gate_rt_in = 2'b01; #1;
        chk("R11", "line0 high synced", gate_o, 1);
        wr_ctl(3'b000, 1'b0, 1'b0, 1'b1, 2'b11);
        #1;
        chk("R11", "line1 low synced", gate_o, 0);
        wr_ctl(3'b000, 1'b0, 1'b0, 1'b1, 2'b00);
        gate_rt_in = 2'b00; #1;
        chk("R11", "lines ignored", gate_o, 1);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_stop();
        t_gate();
        t_timer();
        t_retrig();
        t_dt(3'b100, 2, "R6", 1'b0);
        t_dt(3'b111, 1, "R7", 1'b1);
        t_irq();
        t_pol();
        t_gatesync();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule